// File: doc/BRIEF.md
# Crate Readout Frame Serializer

The block turns one sampling pulse into one byte-wide frame that describes a whole crate. A frame opens with a header: a crate identifier byte, then a 9-byte GPS timestamp. One section per board follows. Each section starts with a board identifier byte and holds one entry per channel. Each entry is a channel identifier byte followed by a 2-byte sample field. The crate identifier and the timestamp are captured when the frame begins. Board and channel identifiers come from the block's own counters.

Samples are pulled one at a time, just before they are needed. The block raises a fetch request carrying a board and channel index. The surrounding logic returns the 14-bit sample combinationally in the same cycle.

The byte stream leaves through a valid/ready handshake. Start-of-frame and end-of-frame markers travel with the data, and the stream may be stalled for any number of cycles. A frame strobe that arrives while a frame is still in flight is dropped and latches an overrun flag.

Top module: `rfs_frame_serializer`

## Requirements
- R1: After reset, tx_valid_o, fetch_req_o and overrun_o are low.
- R2: A frame's first byte is the crate ID captured at the accepted strobe and carries tx_sof_o. The next TS_BYTES bytes are the captured timestamp, most significant byte first.
- R3: After the header come N_BOARDS board sections in ascending order. Each section begins with a board ID byte equal to its zero-based board index, followed by N_CHANS channel entries.
- R4: Each channel entry is 3 bytes: the zero-based channel index, then {2'b00, sample[13:8]}, then sample[7:0].
- R5: A frame is exactly 1 + TS_BYTES + N_BOARDS*(1 + 3*N_CHANS) bytes long. tx_sof_o is high only on its first byte and tx_eof_o only on its last byte, which is the low sample byte of the last board's last channel.
- R6: While tx_valid_o is high and tx_ready_i is low, tx_data_o, tx_sof_o, tx_eof_o and tx_valid_o hold their values, and no byte is lost or repeated.
- R7: A frame_start_i seen while a frame is in progress (sequencer active or a byte still pending at the output) is ignored: the current frame's content is unchanged and no extra frame follows. It sets overrun_o, which stays high until reset.
- R8: fetch_req_o pulses once per channel entry, in frame order. fetch_board_o and fetch_chan_o equal that entry's board and channel index, and sample_i is taken in that same cycle.
- R9: Changes to timestamp_i and crate_id_i after the accepted strobe do not affect the frame being sent.
- R10: After the end-of-frame byte is accepted, tx_valid_o stays low until a new frame_start_i is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Sampling pulse that starts a frame |
| timestamp_i | input | TS_BYTES*8 | GPS time, captured at frame start |
| crate_id_i | input | 8 | Crate identifier, captured at frame start |
| fetch_req_o | output | 1 | Sample fetch strobe |
| fetch_board_o | output | 8 | Board index of the fetch |
| fetch_chan_o | output | 8 | Channel index of the fetch |
| sample_i | input | SAMPLE_W | Sample for the fetched board/channel, valid in the fetch cycle |
| tx_data_o | output | 8 | Output byte |
| tx_valid_o | output | 1 | Output byte valid |
| tx_ready_i | input | 1 | Downstream ready |
| tx_sof_o | output | 1 | Marks the crate ID byte |
| tx_eof_o | output | 1 | Marks the final sample byte |
| overrun_o | output | 1 | Sticky: a strobe arrived during a frame |

## Verification
The bench builds the serializer with 3 boards and 4 channels per board, keeping the 9-byte timestamp and 14-bit samples. A whole frame is then 49 bytes. This puts every board wrap and channel wrap, and the end-of-frame position, within a few dozen cycles, so many frames fit in one run. Those frames use full-throughput, random and mostly-stalled ready patterns, and all-ones and all-zero samples. The short frame also keeps a strobe injected at cycle 25 inside the active frame, which exercises the overrun path.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CRATE, ST_TIME, ST_BOARD, ST_CHAN, ST_SHI, ST_SLO
  } rfs_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       sof;
    logic       eof;
  } rfs_beat_t;
endpackage

// File: rtl/rfs_seq.sv
module rfs_seq
  import rfs_pkg::*;
#(
  parameter int N_BOARDS = 20,
  parameter int N_CHANS  = 16,
  parameter int TS_BYTES = 9,
  localparam int BW = (N_BOARDS > 1) ? $clog2(N_BOARDS) : 1,
  localparam int CW = (N_CHANS > 1) ? $clog2(N_CHANS) : 1,
  localparam int TW = (TS_BYTES > 1) ? $clog2(TS_BYTES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          step_i,
  output rfs_state_e    state_o,
  output logic [BW-1:0] board_o,
  output logic [CW-1:0] chan_o,
  output logic          last_entry_o
);
  localparam logic [BW-1:0] BoardLast = BW'(N_BOARDS - 1);
  localparam logic [CW-1:0] ChanLast  = CW'(N_CHANS - 1);
  localparam logic [TW-1:0] TimeLast  = TW'(TS_BYTES - 1);

  rfs_state_e    state_q;
  logic [BW-1:0] board_q;
  logic [CW-1:0] chan_q;
  logic [TW-1:0] tcnt_q;
  logic          chan_end, board_end;

  assign chan_end  = (chan_q == ChanLast);
  assign board_end = (board_q == BoardLast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      board_q <= '0;
      chan_q  <= '0;
      tcnt_q  <= '0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_q <= ST_CRATE;
        board_q <= '0;
        chan_q  <= '0;
        tcnt_q  <= '0;
      end
    end else if (step_i) begin
      unique case (state_q)
        ST_CRATE: state_q <= ST_TIME;
        ST_TIME: begin
          if (tcnt_q == TimeLast) state_q <= ST_BOARD;
          else tcnt_q <= tcnt_q + 1'b1;
        end
        ST_BOARD: begin
          chan_q  <= '0;
          state_q <= ST_CHAN;
        end
        ST_CHAN: state_q <= ST_SHI;
        ST_SHI:  state_q <= ST_SLO;
        ST_SLO: begin
          if (!chan_end) begin
            chan_q  <= chan_q + 1'b1;
            state_q <= ST_CHAN;
          end else if (!board_end) begin
            board_q <= board_q + 1'b1;
            state_q <= ST_BOARD;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o      = state_q;
  assign board_o      = board_q;
  assign chan_o       = chan_q;
  assign last_entry_o = (state_q == ST_SLO) && chan_end && board_end;
endmodule

// File: rtl/rfs_payload.sv
module rfs_payload
  import rfs_pkg::*;
#(
  parameter int TS_BYTES = 9,
  parameter int SAMPLE_W = 14,
  parameter int BW       = 5,
  parameter int CW       = 4,
  localparam int TSW     = TS_BYTES * 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [TSW-1:0]      ts_i,
  input  logic [7:0]          crate_i,
  input  logic                step_i,
  input  rfs_state_e          state_i,
  input  logic [BW-1:0]       board_i,
  input  logic [CW-1:0]       chan_i,
  input  logic                last_entry_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                fetch_req_o,
  output logic                beat_valid_o,
  output rfs_beat_t           beat_o
);
  logic [7:0]          crate_q;
  logic [TSW-1:0]      ts_q;
  logic [SAMPLE_W-1:0] smp_q;
  logic [15:0]         smp_ext;

  assign fetch_req_o = step_i && (state_i == ST_CHAN);
  assign smp_ext     = 16'(smp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crate_q <= '0;
      ts_q    <= '0;
      smp_q   <= '0;
    end else begin
      if (load_i) begin
        crate_q <= crate_i;
        ts_q    <= ts_i;
      end
      // timestamp leaves MSB first: shift consumed byte out the top
      if (step_i && state_i == ST_TIME) ts_q <= {ts_q[TSW-9:0], 8'h00};
      if (fetch_req_o) smp_q <= sample_i;
    end
  end

  always_comb begin
    beat_o       = '0;
    beat_valid_o = (state_i != ST_IDLE);
    unique case (state_i)
      ST_CRATE: begin
        beat_o.data = crate_q;
        beat_o.sof  = 1'b1;
      end
      ST_TIME:  beat_o.data = ts_q[TSW-1 -: 8];
      ST_BOARD: beat_o.data = 8'(board_i);
      ST_CHAN:  beat_o.data = 8'(chan_i);
      ST_SHI:   beat_o.data = smp_ext[15:8];
      ST_SLO: begin
        beat_o.data = smp_ext[7:0];
        beat_o.eof  = last_entry_i;
      end
      default:  beat_o = '0;
    endcase
  end
endmodule

// File: rtl/rfs_out.sv
module rfs_out
  import rfs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      in_valid_i,
  input  rfs_beat_t in_beat_i,
  output logic      in_take_o,
  output logic      tx_valid_o,
  input  logic      tx_ready_i,
  output rfs_beat_t tx_beat_o
);
  logic      valid_q;
  rfs_beat_t beat_q;
  logic      open_slot;

  assign open_slot = !valid_q || tx_ready_i;
  assign in_take_o = in_valid_i && open_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else if (open_slot) begin
      valid_q <= in_valid_i;
      if (in_valid_i) beat_q <= in_beat_i;
    end
  end

  assign tx_valid_o = valid_q;
  assign tx_beat_o  = beat_q;
endmodule

// File: rtl/rfs_frame_serializer.sv
module rfs_frame_serializer
  import rfs_pkg::*;
#(
  parameter int N_BOARDS = 20,
  parameter int N_CHANS  = 16,
  parameter int TS_BYTES = 9,
  parameter int SAMPLE_W = 14,
  localparam int TSW = TS_BYTES * 8,
  localparam int BW  = (N_BOARDS > 1) ? $clog2(N_BOARDS) : 1,
  localparam int CW  = (N_CHANS > 1) ? $clog2(N_CHANS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_start_i,
  input  logic [TSW-1:0]      timestamp_i,
  input  logic [7:0]          crate_id_i,
  output logic                fetch_req_o,
  output logic [7:0]          fetch_board_o,
  output logic [7:0]          fetch_chan_o,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [7:0]          tx_data_o,
  output logic                tx_valid_o,
  input  logic                tx_ready_i,
  output logic                tx_sof_o,
  output logic                tx_eof_o,
  output logic                overrun_o
);
  rfs_state_e    state;
  logic [BW-1:0] board;
  logic [CW-1:0] chan;
  logic          last_entry, step, busy, start_ok, beat_valid;
  logic          overrun_q;
  rfs_beat_t     beat, tx_beat;

  assign busy     = (state != ST_IDLE) || tx_valid_o;
  assign start_ok = frame_start_i && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) overrun_q <= 1'b0;
    else if (frame_start_i && busy) overrun_q <= 1'b1;
  end

  rfs_seq #(
    .N_BOARDS(N_BOARDS), .N_CHANS(N_CHANS), .TS_BYTES(TS_BYTES)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_i(start_ok), .step_i(step),
    .state_o(state), .board_o(board), .chan_o(chan),
    .last_entry_o(last_entry)
  );

  rfs_payload #(
    .TS_BYTES(TS_BYTES), .SAMPLE_W(SAMPLE_W), .BW(BW), .CW(CW)
  ) u_payload (
    .clk_i, .rst_ni,
    .load_i(start_ok), .ts_i(timestamp_i), .crate_i(crate_id_i),
    .step_i(step), .state_i(state), .board_i(board), .chan_i(chan),
    .last_entry_i(last_entry), .sample_i,
    .fetch_req_o, .beat_valid_o(beat_valid), .beat_o(beat)
  );

  rfs_out u_out (
    .clk_i, .rst_ni,
    .in_valid_i(beat_valid), .in_beat_i(beat), .in_take_o(step),
    .tx_valid_o, .tx_ready_i, .tx_beat_o(tx_beat)
  );

  assign fetch_board_o = 8'(board);
  assign fetch_chan_o  = 8'(chan);
  assign tx_data_o     = tx_beat.data;
  assign tx_sof_o      = tx_beat.sof;
  assign tx_eof_o      = tx_beat.eof;
  assign overrun_o     = overrun_q;
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int N_BOARDS = 20,
  parameter int N_CHANS  = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic       tx_sof_o,
  input logic       tx_eof_o,
  input logic       overrun_o,
  input logic       fetch_req_o,
  input logic [7:0] fetch_board_o,
  input logic [7:0] fetch_chan_o
);
  a_r6_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)
      && $stable(tx_sof_o) && $stable(tx_eof_o));

  a_r5_marks_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !(tx_sof_o && tx_eof_o));

  a_r7_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  a_r8_fetch_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> (32'(fetch_board_o) < N_BOARDS) && (32'(fetch_chan_o) < N_CHANS));

  a_r10_idle_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_eof_o |=> !tx_valid_o);

  a_r8_one_fetch_per_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |=> !fetch_req_o);
endmodule

bind rfs_frame_serializer rfs_checker #(
  .N_BOARDS(N_BOARDS), .N_CHANS(N_CHANS)
) u_rfs_checker (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
  .tx_sof_o(tx_sof_o), .tx_eof_o(tx_eof_o), .overrun_o(overrun_o),
  .fetch_req_o(fetch_req_o), .fetch_board_o(fetch_board_o),
  .fetch_chan_o(fetch_chan_o)
);

// File: tb/rfs_frame_serializer_tb.sv
module rfs_frame_serializer_tb_top;
  localparam int NB   = 3;
  localparam int NC   = 4;
  localparam int TSB  = 9;
  localparam int SW   = 14;
  localparam int FLEN = 1 + TSB + NB * (1 + 3 * NC);

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            frame_start_i = 1'b0;
  logic [TSB*8-1:0] timestamp_i = '0;
  logic [7:0]      crate_id_i = '0;
  logic            fetch_req_o;
  logic [7:0]      fetch_board_o, fetch_chan_o;
  logic [SW-1:0]   sample_i;
  logic [7:0]      tx_data_o;
  logic            tx_valid_o, tx_sof_o, tx_eof_o, overrun_o;
  logic            tx_ready_i = 1'b1;

  int n_vec = 0;
  int n_bad = 0;
  int seed  = 0;
  logic [15:0] lfsr = 16'hace1;
  logic [7:0]  exp_b [FLEN];

  always #4 clk_i = ~clk_i;

  function automatic logic [SW-1:0] smp_f(int b, int c, int s);
    if (s == 3) return '1;
    if (s == 4) return '0;
    return SW'(((b * 1237 + c * 389 + s * 97) ^ 16'h2a5a) & 16'hffff);
  endfunction

  always_comb sample_i = smp_f(int'(fetch_board_o), int'(fetch_chan_o), seed);

  rfs_frame_serializer #(
    .N_BOARDS(NB), .N_CHANS(NC), .TS_BYTES(TSB), .SAMPLE_W(SW)
  ) dut_i (
    .clk_i, .rst_ni, .frame_start_i, .timestamp_i, .crate_id_i,
    .fetch_req_o, .fetch_board_o, .fetch_chan_o, .sample_i,
    .tx_data_o, .tx_valid_o, .tx_ready_i, .tx_sof_o, .tx_eof_o, .overrun_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic build_exp(input logic [TSB*8-1:0] ts, input logic [7:0] crate);
    int k = 0;
    exp_b[k++] = crate;
    for (int i = 0; i < TSB; i++) exp_b[k++] = ts[(TSB-1-i)*8 +: 8];
    for (int b = 0; b < NB; b++) begin
      exp_b[k++] = 8'(b);
      for (int c = 0; c < NC; c++) begin
        logic [15:0] s = 16'(smp_f(b, c, seed));
        exp_b[k++] = 8'(c);
        exp_b[k++] = s[15:8];
        exp_b[k++] = s[7:0];
      end
    end
  endtask

  // R1: reset state at the ports
  task automatic test_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(tx_valid_o == 1'b0, "R1 valid", tx_valid_o, 0);
    chk(fetch_req_o == 1'b0, "R1 fetch", fetch_req_o, 0);
    chk(overrun_o == 1'b0, "R1 overrun", overrun_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(tx_valid_o == 1'b0, "R1 valid after release", tx_valid_o, 0);
  endtask

  // mode: 0 full rate, 1 random ~75%, 2 mostly stalled
  task automatic run_frame(input logic [TSB*8-1:0] ts, input logic [7:0] crate,
                           input int mode, input bit inject, input bit perturb);
    int n = 0, nf = 0, guard = 0;
    bit pstall = 0;
    logic [7:0] pd = '0;
    logic ovr0 = overrun_o;
    build_exp(ts, crate);
    @(negedge clk_i);
    timestamp_i = ts; crate_id_i = crate; frame_start_i = 1'b1;
    @(negedge clk_i);
    frame_start_i = 1'b0;
    while (n < FLEN && guard < 4000) begin
      @(negedge clk_i);
      guard++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
        0: tx_ready_i = 1'b1;
        1: tx_ready_i = lfsr[0] | lfsr[1];
        default: tx_ready_i = lfsr[0] & lfsr[1];
      endcase
      frame_start_i = inject && (guard == 25);
      if (perturb) begin
        timestamp_i = ~ts; crate_id_i = ~crate; // R9
      end
      #1;
      if (pstall)
        chk(tx_valid_o && tx_data_o == pd, "R6 hold", int'(tx_data_o), int'(pd));
      if (fetch_req_o) begin
        chk(int'(fetch_board_o) == nf / NC && int'(fetch_chan_o) == nf % NC, "R8 fetch addr",
            int'({fetch_board_o, fetch_chan_o}), ((nf / NC) << 8) | (nf % NC));
        nf++;
      end
      if (tx_valid_o && tx_ready_i) begin
        chk(tx_data_o == exp_b[n], n == 0 ? "R2 crate" : (n <= TSB ? "R2 time" : "R3/R4 body"),
            int'(tx_data_o), int'(exp_b[n]));
        chk(tx_sof_o == (n == 0) && tx_eof_o == (n == FLEN - 1), "R5 marks",
            int'({tx_sof_o, tx_eof_o}), int'({n == 0, n == FLEN - 1}));
        n++;
      end
      pstall = tx_valid_o && !tx_ready_i;
      pd = tx_data_o;
    end
    frame_start_i = 1'b0;
    tx_ready_i = 1'b1;
    chk(n == FLEN, "R5 length", n, FLEN);
    chk(nf == NB * NC, "R8 fetch count", nf, NB * NC);
    // R10 / R7: no further frame, stream stays idle
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      #1;
      chk(!tx_valid_o, "R10 idle", tx_valid_o, 0);
    end
    chk(overrun_o == (inject | ovr0), "R7 overrun", overrun_o, inject | ovr0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    test_reset();
    seed = 1; run_frame(72'h01_2345_6789_abcd_ef10, 8'h5a, 0, 0, 0);
    seed = 2; run_frame(72'hff_0011_2233_4455_6677, 8'hc3, 1, 0, 0);
    seed = 3; run_frame(72'h80_0000_0000_0000_0001, 8'hff, 2, 0, 0);
    seed = 4; run_frame(72'h00_0000_0000_0000_0000, 8'h00, 1, 0, 1);
    seed = 5; run_frame(72'h12_3456_789a_bcde_f012, 8'h7e, 0, 1, 0);
    seed = 6; run_frame(72'hde_adbe_ef01_0203_0405, 8'h11, 2, 0, 1);
    test_reset();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule